// File: doc/BRIEF.md
# Transmit Test Pattern Generator

This block sits on the one-bit transmit data path of a single line interface channel. In normal operation it forwards the user transmit bit stream. For line testing it can replace that stream with a fixed pattern: continuous ones, continuous zeros, or a 2^15-1 pseudo-random bit sequence. The pseudo-random sequence can be sent inverted.

Two clock-enable strobes arrive in a single clock domain. One belongs to the transmit clock and the other to the master clock. A reference-select bit chooses which strobe times the internal patterns. User data is always timed by the transmit strobe. Every selected strobe produces one output bit, which is registered and shown for one cycle with a valid pulse. The configuration is sampled on the strobe cycle, so a mode change applies from the next active strobe and never splits a bit.

The continuous-zeros pattern has no select code of its own. It is reached by combining the normal-mode code with the master reference.

Top module: `tx_pattern_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first selected strobe, `tx_valid` is 0 and `tx_data` is 0. The sequence generator returns to its all-ones seed.
- R2: With `pat_sel`=00 and `ref_sel`=0, every cycle with `tx_en`=1 gives `tx_valid`=1 in the following cycle, with `tx_data` equal to the `user_data` value sampled on the strobe cycle. `prbs_inv` has no effect in this mode.
- R3: With `pat_sel`=01, every output bit is 1 for either `ref_sel` value. `prbs_inv` has no effect in this mode.
- R4: With `pat_sel`=00 and `ref_sel`=1, every output bit is 0 and is timed by `mclk_en`. `user_data` and `prbs_inv` have no effect in this mode.
- R5: With `pat_sel`=10, the output is the sequence of x^15+x^14+1, most significant stage first. After reset its first 15 bits are 1. Each later bit o[n+15] equals o[n] XOR o[n+1], and the sequence repeats after 32767 bits.
- R6: With `prbs_inv`=1 in `pat_sel`=10, each output bit is the complement of the sequence bit.
- R7: For the internal patterns (01, 10, and 00 with `ref_sel`=1), `ref_sel`=0 takes bits only on `tx_en` and `ref_sel`=1 takes bits only on `mclk_en`. The unselected strobe produces no `tx_valid`.
- R8: `pat_sel`=11 behaves as normal mode. It passes `user_data` on `tx_en` for either `ref_sel` value and ignores `mclk_en`.
- R9: In any cycle with `tx_valid`=0, `tx_data` keeps its previous value.
- R10: The sequence advances only on strobes taken in `pat_sel`=10. Leaving the mode and returning resumes the sequence where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_sel | input | 2 | Pattern select: 00 normal/zeros, 01 ones, 10 PRBS, 11 normal |
| ref_sel | input | 1 | Reference select: 0 transmit strobe, 1 master strobe |
| prbs_inv | input | 1 | Invert the pseudo-random output |
| user_data | input | 1 | User transmit bit |
| tx_en | input | 1 | Transmit clock-enable strobe |
| mclk_en | input | 1 | Master clock-enable strobe |
| tx_data | output | 1 | Transmit bit out |
| tx_valid | output | 1 | One-cycle pulse marking a new `tx_data` bit |

## Verification
The assertions check on every cycle that each valid pulse follows the strobe the mode selects, and that held data stays put between pulses. They also check that the ones, zeros and pass-through modes emit the value their mode requires. The pseudo-random content (seed, recurrence, 32767-bit period, inversion) and the resumption of the sequence after a detour through another mode can only be shown by the bench. It does this by collecting output bits over long runs and checking each new bit against the bits that came before it.

// File: rtl/tpg_pkg.sv
// Shared types for the transmit test pattern generator.
// Assumes: a single clock domain, with clock choice expressed as enable strobes.
package tpg_pkg;
    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_ONES  = 2'd1,
        MODE_ZEROS = 2'd2,
        MODE_PRBS  = 2'd3
    } tpg_mode_t;

    localparam logic [1:0] SEL_NORMAL = 2'b00;
    localparam logic [1:0] SEL_ONES   = 2'b01;
    localparam logic [1:0] SEL_PRBS   = 2'b10;
    localparam logic [1:0] SEL_RSVD   = 2'b11;
endpackage

// File: rtl/tpg_mode_decode.sv
// Turns the pattern and reference selects into an operating mode and the strobe
// that times it. Assumes: user data is always timed by the transmit strobe.
module tpg_mode_decode
    import tpg_pkg::*;
(
    input  logic [1:0] pat_sel,
    input  logic       ref_sel,
    input  logic       tx_en,
    input  logic       mclk_en,
    output tpg_mode_t  mode,
    output logic       step
);
    // Decode the mode from the select codes.
    always_comb begin
        unique case (pat_sel)
            SEL_ONES:   mode = MODE_ONES;
            SEL_PRBS:   mode = MODE_PRBS;
            SEL_NORMAL: mode = ref_sel ? MODE_ZEROS : MODE_PASS;
            default:    mode = MODE_PASS;
        endcase
    end

    // Pick the strobe for this mode.
    always_comb begin
        if (mode == MODE_PASS) step = tx_en;
        else                   step = ref_sel ? mclk_en : tx_en;
    end
endmodule

// File: rtl/tpg_prbs.sv
// Fibonacci LFSR for the pseudo-random pattern. It advances one bit per
// 'advance' and presents its top stage as the current bit.
// Assumes: TAP_HI > TAP_LO, and the seed is nonzero.
module tpg_prbs #(
    parameter int LEN    = 15,
    parameter int TAP_HI = 15,
    parameter int TAP_LO = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic bit_out
);
    localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

    logic [LEN-1:0] sr;
    logic           fb;

    // Feedback from the two polynomial taps.
    always_comb fb = sr[TAP_HI-1] ^ sr[TAP_LO-1];

    // Shift toward the top stage on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= SEED;
        else if (advance) sr <= {sr[LEN-2:0], fb};
    end

    always_comb bit_out = sr[LEN-1];
endmodule

// File: rtl/tpg_out_stage.sv
// Chooses the output bit for the mode and registers it on the active strobe.
// It also raises a one-cycle valid pulse. Assumes: mode and step come from one decode.
module tpg_out_stage
    import tpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  tpg_mode_t mode,
    input  logic      user_data,
    input  logic      prbs_bit,
    input  logic      prbs_inv,
    output logic      tx_data,
    output logic      tx_valid
);
    logic next_bit;

    // Bit source for the current mode.
    always_comb begin
        unique case (mode)
            MODE_ONES:  next_bit = 1'b1;
            MODE_ZEROS: next_bit = 1'b0;
            MODE_PRBS:  next_bit = prbs_bit ^ prbs_inv;
            default:    next_bit = user_data;
        endcase
    end

    // Register the bit on the strobe, and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= 1'b0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= step;
            if (step) tx_data <= next_bit;
        end
    end
endmodule

// File: rtl/tx_pattern_gen.sv
// Top of the transmit test pattern generator: pass-through, ones, zeros or
// 2^15-1 pseudo-random data on a one-bit transmit stream.
// Assumes: both strobes are synchronous to clk.
module tx_pattern_gen
    import tpg_pkg::*;
#(
    parameter int PRBS_LEN = 15,
    parameter int PRBS_TAP = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pat_sel,
    input  logic       ref_sel,
    input  logic       prbs_inv,
    input  logic       user_data,
    input  logic       tx_en,
    input  logic       mclk_en,
    output logic       tx_data,
    output logic       tx_valid
);
    tpg_mode_t mode;
    logic      step;
    logic      prbs_bit;
    logic      prbs_adv;

    tpg_mode_decode u_dec (
        .pat_sel (pat_sel),
        .ref_sel (ref_sel),
        .tx_en   (tx_en),
        .mclk_en (mclk_en),
        .mode    (mode),
        .step    (step)
    );

    // The sequence moves only on strobes taken in PRBS mode.
    always_comb prbs_adv = step && (mode == MODE_PRBS);

    tpg_prbs #(
        .LEN    (PRBS_LEN),
        .TAP_HI (PRBS_LEN),
        .TAP_LO (PRBS_TAP)
    ) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (prbs_adv),
        .bit_out (prbs_bit)
    );

    tpg_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .mode      (mode),
        .user_data (user_data),
        .prbs_bit  (prbs_bit),
        .prbs_inv  (prbs_inv),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid)
    );
endmodule

// File: rtl/tpg_checker.sv
// Port-level properties of the transmit test pattern generator, bound to its top.
module tpg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pat_sel,
    input logic       ref_sel,
    input logic       user_data,
    input logic       tx_en,
    input logic       mclk_en,
    input logic       tx_data,
    input logic       tx_valid
);
    logic norm_mode;
    logic exp_strobe;

    // Normal mode and the strobe that mode expects, from the ports.
    always_comb begin
        norm_mode  = (pat_sel == 2'b11) || (pat_sel == 2'b00 && !ref_sel);
        exp_strobe = norm_mode ? tx_en : (ref_sel ? mclk_en : tx_en);
    end

    // R7
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(exp_strobe));

    // R7
    strobe_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_strobe |=> tx_valid);

    // R9
    hold_between_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> $stable(tx_data));

    // R3
    ones_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(pat_sel) == 2'b01) |-> tx_data);

    // R4
    zeros_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(pat_sel) == 2'b00 && $past(ref_sel)) |-> !tx_data);

    // R2 R8
    pass_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(norm_mode)) |-> tx_data == $past(user_data));
endmodule

bind tx_pattern_gen tpg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat_sel   (pat_sel),
    .ref_sel   (ref_sel),
    .user_data (user_data),
    .tx_en     (tx_en),
    .mclk_en   (mclk_en),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid)
);

// File: tb/tx_pattern_gen_test.sv
module tx_pattern_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD_LEN = 32767;
    localparam int NVEC = 17;
    // {pat_sel[1:0], ref_sel, inv, user, tx_en, mclk_en, exp_valid, exp_data, req[3:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {2'b00,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b1, 4'd2},
        {2'b00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd2},
        {2'b00,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'd7},
        {2'b00,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b1, 4'd2},
        {2'b01,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'd3},
        {2'b01,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1, 4'd7},
        {2'b01,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1, 4'd7},
        {2'b01,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'd3},
        {2'b00,1'b1,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1, 4'd4},
        {2'b00,1'b1,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0, 4'd4},
        {2'b00,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0, 4'd4},
        {2'b11,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b1, 4'd8},
        {2'b11,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd8},
        {2'b11,1'b1,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'd8},
        {2'b01,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'd3},
        {2'b00,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd2},
        {2'b01,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd9}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       ref_sel = 1'b0;
    logic       prbs_inv = 1'b0;
    logic       user_data = 1'b0;
    logic       tx_en = 1'b0;
    logic       mclk_en = 1'b0;
    logic       tx_data;
    logic       tx_valid;

    int checks = 0;
    int failures = 0;
    logic [14:0] hist;
    int          nbits;
    logic [14:0] first15;

    tx_pattern_gen uut (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .ref_sel(ref_sel),
        .prbs_inv(prbs_inv), .user_data(user_data), .tx_en(tx_en),
        .mclk_en(mclk_en), .tx_data(tx_data), .tx_valid(tx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the next edge.
    task automatic drive(input logic [1:0] ps, input logic rs, input logic inv,
                         input logic ud, input logic te, input logic me);
        @(negedge clk);
        pat_sel = ps; ref_sel = rs; prbs_inv = inv; user_data = ud;
        tx_en = te; mclk_en = me;
        @(posedge clk);
        #1;
    endtask

    // Take one PRBS bit and check it against the recurrence from earlier bits.
    task automatic prbs_bit(input logic inv, input logic use_m, input string req);
        logic raw;
        drive(2'b10, use_m, inv, 1'b0, !use_m, use_m);
        check("R7", {1'b0, tx_valid}, 2'b01);
        raw = tx_data ^ inv;
        if (nbits < 15) check("R5", {1'b0, raw}, 2'b01);
        else            check(req, {1'b0, raw}, {1'b0, hist[14] ^ hist[13]});
        hist = {hist[13:0], raw};
        nbits++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        // R1: reset state, with strobes active
        tx_en = 1'b1; mclk_en = 1'b1; user_data = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1", {tx_valid, tx_data}, 2'b00);
        @(negedge clk);
        tx_en = 1'b0; mclk_en = 1'b0; rst_n = 1'b1;
        @(posedge clk); #1 check("R1", {tx_valid, tx_data}, 2'b00);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            drive(v[12:11], v[10], v[9], v[8], v[7], v[6]);
            check($sformatf("R%0d", v[3:0]), {tx_valid, tx_data}, v[5:4]);
        end

        // R5 seed and recurrence, transmit strobe with gaps
        hist = '0; nbits = 0;
        for (int i = 0; i < 40; i++) begin
            prbs_bit(1'b0, 1'b0, "R5");
            drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            check("R7", {tx_valid, 1'b0}, 2'b00);
        end
        // R10: detour through ones, then resume
        for (int i = 0; i < 4; i++) begin
            drive(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check("R10", {tx_valid, tx_data}, 2'b11);
        end
        for (int i = 0; i < 30; i++) prbs_bit(1'b0, 1'b0, "R10");
        // R6: inverted output still follows the sequence
        for (int i = 0; i < 30; i++) prbs_bit(1'b1, 1'b1, "R6");

        // R5 period: restart from seed and run one full period
        @(negedge clk); rst_n = 1'b0; tx_en = 1'b0; mclk_en = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        hist = '0; nbits = 0;
        for (int i = 0; i < PERIOD_LEN; i++) prbs_bit(1'b0, 1'b1, "R5");
        first15 = '0;
        for (int i = 0; i < 15; i++) begin
            drive(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
            first15 = {first15[13:0], tx_data};
        end
        check("R5", {1'b0, &first15}, 2'b01);

        @(negedge clk); mclk_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule